// File: doc/BRIEF.md
# Programmable Serial Bit-Rate Generator

This block derives the bit timing of an asynchronous serial channel from the main system clock. A 7-bit rate setting holds two fields. The prescaler field chooses a power-of-two divider of the system clock, and the resulting period is called T. The modulus field chooses how many T periods a 5-bit counter counts before it wraps, which is 16 plus k. The counter wraps twice per bit. The first wrap marks the bit centre, where the receiver should sample, and the second wrap marks the bit boundary. A bit therefore lasts 2^(n+1) × (16 + k) system clocks, where n is the prescaler field plus one.

Each output is a registered pulse one clock wide. `baud_tick` marks a bit boundary and `mid_sample` marks a bit centre. While the receiver is hunting for a start bit, a falling edge on the receive line restarts the timing. The first centre strobe then lands half a bit after the edge, and every later strobe lands on a bit centre of the frame. A new rate written while the generator runs is held back until the next bit boundary, so no bit is ever cut short.

Top module: `baud_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are low after that edge, and the prescaler, the counter and any pending rate are cleared.
- R2: `cfg_in[6:4]` is the prescaler field f and `cfg_in[3:0]` is the modulus field k. While running with no restart, `baud_tick` pulses every 2^(f+2) × (16 + k) clocks.
- R3: A setting of 7'h20 gives a bit period of 256 clocks, which is 31250 bit/s at an 8 MHz system clock.
- R4: A modulus field of 15 behaves exactly like 14.
- R5: While `en` and `rx_hunt` are high, a clock edge that sees `rx_in` low after it was high in the previous cycle restarts the timing. `mid_sample` then pulses 2^(f+1) × (16 + k) clocks later, and `baud_tick` pulses the same number of clocks after that.
- R6: When `rx_hunt` is low, edges on `rx_in` do not disturb the bit timing.
- R7: Each pulse on either output lasts one clock, the two outputs are never high together, and `mid_sample` falls exactly halfway between two `baud_tick` pulses.
- R8: A setting written while `en` is high does not change the bit in progress. It takes effect from the next `baud_tick` onwards.
- R9: A setting written in the same cycle as the edge that produces `baud_tick` applies to the very next bit.
- R10: While `en` is low, both outputs stay low, receive-line edges are ignored, and a written setting takes effect at once.
- R11: When a restart falls on the edge that would produce `baud_tick`, the restart wins. No tick is issued, and the next `mid_sample` comes half a bit after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Run enable; low holds the generator idle |
| cfg_we | input | 1 | Write strobe for the rate setting |
| cfg_in | input | 7 | Rate setting: [6:4] prescaler field, [3:0] modulus field |
| rx_in | input | 1 | Receive line, already synchronous to `clk` |
| rx_hunt | input | 1 | High while the receiver waits for a start bit |
| baud_tick | output | 1 | One-clock pulse at each bit boundary |
| mid_sample | output | 1 | One-clock pulse at each bit centre |

## Verification
Two things can fall on one edge: a rate write and the bit-boundary wrap, or a start-edge restart and that same wrap. The bench times its stimulus so that the write, or the receive-line drop, is captured on exactly the edge that wraps the counter. For the write case, the length of the following bit shows whether the new rate applied at once, as it should, and was not held for one more bit. For the restart case, the bench judges by a missing tick on that edge and by a centre strobe exactly half a bit later. Sweeps over every prescaler value and every modulus value, including the reserved one, compare each measured interval against the arithmetic period.

// File: rtl/baud_pkg.sv
package baud_pkg;
    localparam int PSEL_W   = 3;
    localparam int KSEL_W   = 4;
    localparam int CNT_W    = 5;
    localparam int MOD_BASE = 16;
    localparam int K_MAX    = 14;
    localparam int CFG_W    = PSEL_W + KSEL_W;
    localparam int PRE_W    = 1 << PSEL_W;
    localparam int PSH_W    = PSEL_W + 1;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [KSEL_W-1:0] ksel;
    } rate_cfg_t;
endpackage

// File: rtl/baud_cfg.sv
module baud_cfg
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             apply,
    output rate_cfg_t        act
);
    typedef struct packed {
        rate_cfg_t act;
        rate_cfg_t pend;
        logic      pend_v;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    rate_cfg_t  incoming;

    always_comb begin
        incoming.psel = wdata[KSEL_W +: PSEL_W];
        // reserved modulus code saturates to the largest legal one (R4)
        incoming.ksel = (wdata[KSEL_W-1:0] > KSEL_W'(K_MAX)) ? KSEL_W'(K_MAX)
                                                             : wdata[KSEL_W-1:0];
        st_d = st_q;
        if (!en) begin
            // idle: load straight away (R10)
            if (we) begin
                st_d.act = incoming;
            end else if (st_q.pend_v) begin
                st_d.act = st_q.pend;
            end
            st_d.pend_v = 1'b0;
        end else if (apply && (we || st_q.pend_v)) begin
            // bit boundary: newest value wins, even if written this cycle (R8, R9)
            st_d.act    = we ? incoming : st_q.pend;
            st_d.pend_v = 1'b0;
        end else if (we) begin
            st_d.pend   = incoming;
            st_d.pend_v = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act = st_q.act;
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PSEL_W-1:0] psel,
    output logic              t_tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t     st_d, st_q;
    logic [PRE_W:0] span;
    logic           hit;

    always_comb begin
        // divider is 2^(psel+1) clocks
        span   = (PRE_W+1)'(1) << ({1'b0, psel} + PSH_W'(1));
        hit    = ({1'b0, st_q.cnt} == (span - (PRE_W+1)'(1)));
        t_tick = !clr && hit;
        st_d   = st_q;
        if (clr || hit) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PRE_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/baud_bitcnt.sv
module baud_bitcnt
    import baud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              t_tick,
    input  logic [KSEL_W-1:0] ksel,
    output logic              mid_hit,
    output logic              end_hit
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             half;
    } bit_state_t;

    bit_state_t       st_d, st_q;
    logic [CNT_W-1:0] last;
    logic             wrap;

    always_comb begin
        last    = CNT_W'(MOD_BASE - 1) + CNT_W'(ksel);
        wrap    = t_tick && (st_q.cnt == last);
        // first wrap of a bit is its centre, second is its boundary
        mid_hit = wrap && !st_q.half;
        end_hit = wrap && st_q.half;
        st_d    = st_q;
        if (clr) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else if (wrap) begin
            st_d.cnt  = '0;
            st_d.half = !st_q.half;
        end else if (t_tick) begin
            st_d.cnt  = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/baud_gen.sv
module baud_gen
    import baud_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_in,
    input  logic             rx_in,
    input  logic             rx_hunt,
    output logic             baud_tick,
    output logic             mid_sample
);
    typedef struct packed {
        logic rx_prev;
        logic tick;
        logic mid;
    } top_state_t;

    top_state_t st_d, st_q;
    rate_cfg_t  rate;
    logic       restart;
    logic       clr;
    logic       t_tick;
    logic       mid_hit;
    logic       end_hit;

    baud_cfg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .we    (cfg_we),
        .wdata (cfg_in),
        .apply (end_hit),
        .act   (rate)
    );

    baud_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (clr),
        .psel   (rate.psel),
        .t_tick (t_tick)
    );

    baud_bitcnt u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .t_tick  (t_tick),
        .ksel    (rate.ksel),
        .mid_hit (mid_hit),
        .end_hit (end_hit)
    );

    always_comb begin
        // start edge while hunting restarts the timing and outranks a wrap (R5, R11)
        restart    = en && rx_hunt && st_q.rx_prev && !rx_in;
        clr        = !en || restart;
        st_d       = st_q;
        st_d.rx_prev = rx_in;
        st_d.tick  = end_hit;
        st_d.mid   = mid_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.rx_prev <= 1'b1;
            st_q.tick    <= 1'b0;
            st_q.mid     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign baud_tick  = st_q.tick;
    assign mid_sample = st_q.mid;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic rx_in,
    input logic rx_hunt,
    input logic baud_tick,
    input logic mid_sample
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!baud_tick && !mid_sample));

    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick);

    assert_mid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mid_sample |=> !mid_sample);

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(baud_tick && mid_sample));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!baud_tick && !mid_sample));

    assert_restart_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_hunt && !rx_in && $past(rx_in)) |=> (!baud_tick && !mid_sample));
endmodule

bind baud_gen baud_gen_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .rx_in      (rx_in),
    .rx_hunt    (rx_hunt),
    .baud_tick  (baud_tick),
    .mid_sample (mid_sample)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
    localparam int LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_in = '0;
    logic       rx_in = 1'b1;
    logic       rx_hunt = 1'b0;
    logic       baud_tick;
    logic       mid_sample;

    int checks = 0;
    int errors = 0;

    baud_gen i_baud_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cfg_we     (cfg_we),
        .cfg_in     (cfg_in),
        .rx_in      (rx_in),
        .rx_hunt    (rx_hunt),
        .baud_tick  (baud_tick),
        .mid_sample (mid_sample)
    );

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_eq(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wait_for(input bit want_tick, output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!(want_tick ? baud_tick : mid_sample) && n < LIMIT);
    endtask

    task automatic load_idle(input logic [6:0] v);
        en = 1'b0;
        rx_in = 1'b1;
        cfg_we = 1'b1;
        cfg_in = v;
        step();
        cfg_we = 1'b0;
        step();
    endtask

    // restart -> centre -> boundary -> boundary, all compared to arithmetic
    task automatic measure(input int f, input int k, input string tag);
        int p, m, n, mid_at;
        p = 1 << (f + 1);
        m = 16 + ((k > 14) ? 14 : k);
        load_idle(7'((f << 4) | k));
        en = 1'b1;
        rx_hunt = 1'b1;
        rx_in = 1'b1;
        step();
        rx_in = 1'b0;
        wait_for(1'b0, n);
        check_eq({tag, " /R5 edge to centre"}, n, m * p + 1);
        rx_hunt = 1'b0;
        wait_for(1'b1, n);
        check_eq({tag, " /R5 centre to boundary"}, n, m * p);
        n = 0;
        mid_at = -1;
        do begin
            step();
            n++;
            if (mid_sample) mid_at = n;
        end while (!baud_tick && n < LIMIT);
        check_eq({tag, " bit period"}, n, 2 * m * p);
        check_eq({tag, " /R7 centre position"}, mid_at, m * p);
        en = 1'b0;
        step();
    endtask

    // count to next tick; optionally write a setting at iteration wa
    task automatic run_to_tick(input int wa, input logic [6:0] wv, output int n);
        n = 0;
        forever begin
            step();
            n++;
            cfg_we = 1'b0;
            if (baud_tick || n >= LIMIT) break;
            if (n == wa) begin
                cfg_we = 1'b1;
                cfg_in = wv;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, pulses;

        // R1: reset state
        rst_n = 1'b0;
        en = 1'b1;
        rx_hunt = 1'b1;
        repeat (5) step();
        check_eq("R1 baud_tick in reset", int'(baud_tick), 0);
        check_eq("R1 mid_sample in reset", int'(mid_sample), 0);
        en = 1'b0;
        rst_n = 1'b1;

        // R10: idle generator stays quiet and ignores the line
        pulses = 0;
        for (int i = 0; i < 150; i++) begin
            rx_in = (i % 3) != 0;
            step();
            if (baud_tick || mid_sample) pulses++;
        end
        check_eq("R10 pulses while disabled", pulses, 0);

        // R2: every prescaler value
        for (int f = 0; f < 8; f++) measure(f, 0, "R2 prescaler sweep");
        // R2/R4: every modulus value, 15 reserved
        for (int k = 0; k < 15; k++) measure(0, k, "R2 modulus sweep");
        measure(0, 15, "R4 reserved modulus");
        measure(1, 15, "R4 reserved modulus");
        // R3: documented example setting, immediate load while idle (R10)
        measure(2, 0, "R3 setting 7'h20 / R10 idle load");

        // R6: line edges ignored while not hunting
        load_idle(7'h00);
        en = 1'b1;
        rx_hunt = 1'b0;
        wait_for(1'b1, n);
        n = 0;
        pulses = -1;
        do begin
            step();
            n++;
            if (n == 10) rx_in = 1'b0;
            if (n == 20) rx_in = 1'b1;
            if (n == 30) rx_in = 1'b0;
            if (mid_sample) pulses = n;
        end while (!baud_tick && n < LIMIT);
        check_eq("R6 period with line activity", n, 64);
        check_eq("R6 centre position", pulses, 32);

        // R8: mid-bit write is deferred to the next boundary
        rx_in = 1'b1;
        run_to_tick(3, 7'h04, n);
        check_eq("R8 bit in progress keeps old rate", n, 64);
        run_to_tick(0, 7'h00, n);
        check_eq("R8 new rate after boundary", n, 80);

        // R9: write captured on the boundary edge applies to the next bit
        run_to_tick(79, 7'h00, n);
        check_eq("R9 boundary bit length", n, 80);
        run_to_tick(0, 7'h00, n);
        check_eq("R9 next bit uses new rate", n, 64);

        // R11: restart on the boundary edge suppresses the tick
        rx_hunt = 1'b1;
        rx_in = 1'b1;
        n = 0;
        forever begin
            step();
            n++;
            if (n == 63) rx_in = 1'b0;
            if (n == 64 || baud_tick || n >= LIMIT) break;
        end
        check_eq("R11 tick on restart edge", int'(baud_tick), 0);
        check_eq("R11 centre on restart edge", int'(mid_sample), 0);
        rx_hunt = 1'b0;
        wait_for(1'b0, n);
        check_eq("R11 centre after restart", n, 32);
        wait_for(1'b1, n);
        check_eq("R11 boundary after centre", n, 32);

        en = 1'b0;
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule